// File: doc/BRIEF.md
# FM Operator Phase Generator

This block produces the running phase for each operator of a four-operator FM voice. The voice shares one pitch setting, an 11-bit frequency number and a 3-bit octave, and each operator adds its own small detune offset and frequency ratio on top of it. On every sample strobe each operator's phase accumulator advances by its own increment. When an operator's key goes from released to pressed, its phase restarts from zero.

Pitch is written in two steps. A write to the high frequency field only loads a holding latch. The following write to the low frequency field commits the latch and the low byte together, so a pitch change never takes effect half done. The block also outputs a 5-bit key code formed from the octave and the top frequency bits, which an envelope stage can use for rate scaling.

The sine lookup, low-frequency modulation and envelope logic sit outside this block.

Top module: `fm_phase_gen`

## Requirements
- R1: After reset every operator phase is 0, the key code is 0, frequency number and octave are 0, and every operator has detune 0 and ratio field 0.
- R2: A write with `wr_sel`=1 loads a holding latch only: data bits 2:0 become the pending frequency bits 10:8 and data bits 5:3 the pending octave. The key code and the increments do not change.
- R3: A write with `wr_sel`=0 sets the frequency number to {latch bits 2:0, data 7:0} and the octave to latch bits 5:3. The key code shows the new value in the cycle after the write edge.
- R4: The key code is {octave, t}, where t is 0 when frequency bits 10:7 are 0 to 6, 1 when they are 7, 2 when they are 8, and 3 when they are 9 to 15.
- R5: The base increment is (frequency number × 4) shifted right by (7 − octave).
- R6: A write with `wr_sel`=2 sets the ratio field of operator `wr_op` from data bits 3:0 and its detune field from data bits 6:4. Detune bit 2 makes the offset negative. Detune bits 1:0 give a row r, and the offset magnitude is r × ((key code >> 1) + 1).
- R7: An operator's increment is (base ± offset) × ratio, taken modulo 2^20. The offset is applied before the multiply. Ratio field 0 means one half: the signed sum is shifted right arithmetically by one.
- R8: On a cycle with `sample_en` high, each phase becomes (phase + increment) mod 2^20. Without the strobe the phase holds.
- R9: When an operator's `key_on` bit rises, its phase is 0 on the next cycle, and this wins over a strobe in the same cycle. A `key_on` bit that stays high never clears the phase.
- R10: A register write changes the increment used by any strobe from the next cycle on. A strobe in the same cycle as the write still uses the old increment.
- R11: A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select: 0 frequency low, 1 frequency high latch, 2 operator detune/ratio, 3 none |
| wr_op | input | 2 | Operator addressed by a detune/ratio write |
| wr_data | input | 8 | Write data |
| key_on | input | 4 | Per-operator key state; a rising bit restarts that phase |
| sample_en | input | 1 | Sample tick; advances all accumulators |
| phase | output | 80 | Four 20-bit phases, operator 0 in the low bits |
| key_code | output | 5 | Key code of the committed pitch |

## Verification
Assertions watch the accumulators on every cycle. They check that a phase holds without a strobe, that it advances by exactly the increment the arithmetic presents, and that a key rise clears it. They also check that a high-latch write or a write with the unused select leaves the committed pitch and the operator settings unchanged. Whether those increments are the right numbers cannot be seen from inside an assertion. The bench's vectors show it, along with the key-code table, the order of detune before the ratio multiply, the half ratio applied to negative sums, wrap at 2^20, and the one-cycle lag of a write against a strobe.

// File: rtl/fm_pg_pkg.sv
package fm_pg_pkg;

    parameter int FNUM_W = 11;
    parameter int BLK_W  = 3;
    parameter int DT_W   = 3;
    parameter int MUL_W  = 4;
    parameter int KC_W   = BLK_W + 2;
    parameter int MAG_W  = 7;

    typedef enum logic [1:0] {
        SEL_FREQ_LO = 2'd0,
        SEL_FREQ_HI = 2'd1,
        SEL_OP_CFG  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [FNUM_W-1:0] fnum;
    } freq_t;

    typedef struct packed {
        logic [DT_W-1:0]  dt;
        logic [MUL_W-1:0] mul;
    } op_cfg_t;

    // fractional key position from the top four frequency bits
    function automatic logic [1:0] kc_frac(input logic [3:0] top);
        if (top <= 4'd6)      return 2'd0;
        else if (top == 4'd7) return 2'd1;
        else if (top == 4'd8) return 2'd2;
        else                  return 2'd3;
    endfunction

    function automatic logic [KC_W-1:0] make_keycode(input freq_t f);
        return {f.blk, kc_frac(f.fnum[FNUM_W-1 -: 4])};
    endfunction

    // offset magnitude grows with row and with key code
    function automatic logic [MAG_W-1:0] detune_mag(input logic [1:0] row,
                                                    input logic [KC_W-1:0] kc);
        return MAG_W'(row) * (MAG_W'(kc >> 1) + MAG_W'(1));
    endfunction

endpackage

// File: rtl/fm_pg_regs.sv
module fm_pg_regs
    import fm_pg_pkg::*;
#(
    parameter int NUM_OPS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [$clog2(NUM_OPS)-1:0] wr_op,
    input  logic [7:0]                 wr_data,
    output freq_t                      freq,
    output op_cfg_t [NUM_OPS-1:0]      cfg
);

    localparam int LATCH_W = BLK_W + (FNUM_W - 8);

    logic [LATCH_W-1:0] hi_latch;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_latch <= '0;
            freq     <= '0;
            cfg      <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_FREQ_HI: hi_latch <= wr_data[LATCH_W-1:0];
                SEL_FREQ_LO: begin
                    freq.blk  <= hi_latch[LATCH_W-1 -: BLK_W];
                    freq.fnum <= {hi_latch[FNUM_W-9:0], wr_data};
                end
                SEL_OP_CFG: begin
                    cfg[wr_op].dt  <= wr_data[MUL_W +: DT_W];
                    cfg[wr_op].mul <= wr_data[MUL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    AST_HI_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_FREQ_HI) |=> $stable(freq) && $stable(cfg)); // R2

    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> $stable(freq) && $stable(cfg) && $stable(hi_latch)); // R11

endmodule

// File: rtl/fm_pg_incr.sv
module fm_pg_incr
    import fm_pg_pkg::*;
#(
    parameter int PHASE_W    = 20,
    parameter int OCT7_SHIFT = 2
) (
    input  freq_t               freq,
    input  op_cfg_t             cfg,
    output logic [PHASE_W-1:0]  inc
);

    localparam int BASE_W = FNUM_W + OCT7_SHIFT;
    localparam int DET_W  = PHASE_W + 1;
    localparam int FAC_W  = MUL_W + 2;
    localparam int PROD_W = DET_W + FAC_W;

    logic [BASE_W-1:0]        base;
    logic [KC_W-1:0]          kc;
    logic [MAG_W-1:0]         mag;
    logic signed [DET_W-1:0]  det;
    logic signed [FAC_W-1:0]  fac;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        base = (BASE_W'(freq.fnum) << OCT7_SHIFT) >> (3'd7 - freq.blk);
        kc   = make_keycode(freq);
        mag  = detune_mag(cfg.dt[1:0], kc);
        // offset joins the base before the ratio multiply
        if (cfg.dt[DT_W-1])
            det = $signed(DET_W'(base)) - $signed(DET_W'(mag));
        else
            det = $signed(DET_W'(base)) + $signed(DET_W'(mag));
        // ratio in halves: field 0 is one half, otherwise twice the field
        fac  = (cfg.mul == '0) ? FAC_W'(1) : $signed({1'b0, cfg.mul, 1'b0});
        prod = PROD_W'(det) * PROD_W'(fac);
        inc  = prod[PHASE_W:1];
    end

endmodule

// File: rtl/fm_pg_accum.sv
module fm_pg_accum #(
    parameter int PHASE_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_on,
    input  logic               sample_en,
    input  logic [PHASE_W-1:0] inc,
    output logic [PHASE_W-1:0] phase
);

    logic key_q;
    logic key_rise;

    assign key_rise = key_on & ~key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= 1'b0;
            phase <= '0;
        end else begin
            key_q <= key_on;
            if (key_rise)
                phase <= '0;
            else if (sample_en)
                phase <= phase + inc;
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        key_rise |=> (phase == '0)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!key_rise && !sample_en) |=> $stable(phase)); // R8

    AST_STEP_BY_INC: assert property (@(posedge clk) disable iff (rst)
        (!key_rise && sample_en) |=> (phase == $past(phase + inc))); // R8

endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
    import fm_pg_pkg::*;
#(
    parameter int NUM_OPS    = 4,
    parameter int PHASE_W    = 20,
    parameter int OCT7_SHIFT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [$clog2(NUM_OPS)-1:0] wr_op,
    input  logic [7:0]                 wr_data,
    input  logic [NUM_OPS-1:0]         key_on,
    input  logic                       sample_en,
    output logic [NUM_OPS*PHASE_W-1:0] phase,
    output logic [KC_W-1:0]            key_code
);

    freq_t                 freq;
    op_cfg_t [NUM_OPS-1:0] cfg;

    fm_pg_regs #(.NUM_OPS(NUM_OPS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .freq    (freq),
        .cfg     (cfg)
    );

    assign key_code = make_keycode(freq);

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic [PHASE_W-1:0] op_inc;

        fm_pg_incr #(.PHASE_W(PHASE_W), .OCT7_SHIFT(OCT7_SHIFT)) u_incr (
            .freq (freq),
            .cfg  (cfg[g]),
            .inc  (op_inc)
        );

        fm_pg_accum #(.PHASE_W(PHASE_W)) u_accum (
            .clk       (clk),
            .rst       (rst),
            .key_on    (key_on[g]),
            .sample_en (sample_en),
            .inc       (op_inc),
            .phase     (phase[g*PHASE_W +: PHASE_W])
        );
    end

endmodule

// File: tb/test_fm_phase_gen.sv
module test_fm_phase_gen;

    localparam int NUM_OPS = 4;
    localparam int PHASE_W = 20;
    localparam int PMASK   = (1 << PHASE_W) - 1;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       wr_en = 1'b0;
    logic [1:0]                 wr_sel = '0;
    logic [1:0]                 wr_op = '0;
    logic [7:0]                 wr_data = '0;
    logic [NUM_OPS-1:0]         key_on = '0;
    logic                       sample_en = 1'b0;
    logic [NUM_OPS*PHASE_W-1:0] phase;
    logic [4:0]                 key_code;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    // committed pitch as the bench understands it
    int m_fn = 0, m_blk = 0, m_hi = 0;

    always #4 clk = ~clk;

    fm_phase_gen i_fm_phase_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_op(wr_op),
        .wr_data(wr_data), .key_on(key_on), .sample_en(sample_en),
        .phase(phase), .key_code(key_code)
    );

    // fields: freq-high data, freq-low data, op cfg data, op index, expected key code
    localparam logic [39:0] VECS [8] = '{
        40'h3C_00_01_00_1E,
        40'h00_55_00_01_00,
        40'h13_80_15_02_09,
        40'h2F_FF_7F_03_17,
        40'h24_80_62_00_13,
        40'h03_7F_50_01_00,
        40'h39_00_3A_02_1C,
        40'h00_04_70_03_00
    };

    function automatic int model_kc(int fn, int blk);
        int top = (fn >> 7) & 15;
        int t = (top <= 6) ? 0 : (top == 7) ? 1 : (top == 8) ? 2 : 3;
        return (blk << 2) | t;
    endfunction

    function automatic int model_inc(int fn, int blk, int cfgv);
        int base = (fn * 4) >> (7 - blk);
        int row  = (cfgv >> 4) & 3;
        int mag  = row * ((model_kc(fn, blk) >> 1) + 1);
        int det  = ((cfgv >> 6) & 1) ? base - mag : base + mag;
        int mul  = cfgv & 15;
        int p    = (mul == 0) ? (det >>> 1) : det * mul;
        return p & PMASK;
    endfunction

    function automatic int ph(int op);
        return int'(phase[op*PHASE_W +: PHASE_W]);
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp_v);
        end
    endtask

    task automatic wr(input int sel, input int op, input int d);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_op = 2'(op); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 1) m_hi = d & 8'h3F;
        if (sel == 0) begin m_fn = ((m_hi & 7) << 8) | d; m_blk = (m_hi >> 3) & 7; end
    endtask

    task automatic restart(input int op);
        key_on[op] = 1'b0;
        @(negedge clk);
        key_on[op] = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe();
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    initial begin
        int cfg_now [4] = '{0, 0, 0, 0};
        int prev_kc = 0;
        int inc_a, inc_b, hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int o = 0; o < NUM_OPS; o++) chk("R1 phase", ph(o), 0);
        chk("R1 key code", int'(key_code), 0);

        for (int v = 0; v < 8; v++) begin
            int hi = int'(VECS[v][39:32]);
            int lo = int'(VECS[v][31:24]);
            int cf = int'(VECS[v][23:16]);
            int op = int'(VECS[v][15:8]);
            int kc = int'(VECS[v][7:0]);
            int inc;
            wr(1, 0, hi);
            chk("R2 latch only", int'(key_code), prev_kc);
            wr(0, 0, lo);
            chk("R3 R4 key code", int'(key_code), kc);
            chk("R4 model", kc, model_kc(m_fn, m_blk));
            prev_kc = kc;
            wr(2, op, cf);
            cfg_now[op] = cf;
            restart(op);
            chk("R9 restart", ph(op), 0);
            inc = model_inc(m_fn, m_blk, cf);
            strobe();
            chk("R5 R6 R7 increment", ph(op), inc);
            strobe();
            chk("R8 second step", ph(op), (2 * inc) & PMASK);
        end

        // R8: no strobe, phase holds
        hold = ph(3);
        repeat (4) @(negedge clk);
        chk("R8 hold", ph(3), hold);

        // R9: key held high does not clear; rise beats strobe
        strobe();
        chk("R9 held key", ph(3), (hold + model_inc(m_fn, m_blk, cfg_now[3])) & PMASK);
        key_on[3] = 1'b0;
        @(negedge clk);
        key_on[3] = 1'b1;
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        chk("R9 rise over strobe", ph(3), 0);

        // R10: write and strobe in one cycle use the old ratio
        wr(1, 0, 8'h3C);
        wr(0, 0, 8'h00);
        wr(2, 0, 8'h62);
        restart(0);
        inc_a = model_inc(m_fn, m_blk, 8'h62);
        inc_b = model_inc(m_fn, m_blk, 8'h01);
        wr_en = 1'b1; wr_sel = 2'd2; wr_op = 2'd0; wr_data = 8'h01;
        sample_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sample_en = 1'b0;
        chk("R10 same-cycle old inc", ph(0), inc_a);
        strobe();
        chk("R10 next strobe new inc", ph(0), (inc_a + inc_b) & PMASK);

        // R11: unused select changes nothing
        wr(3, 0, 8'hFF);
        chk("R11 key code", int'(key_code), model_kc(m_fn, m_blk));
        restart(0);
        strobe();
        chk("R11 increment", ph(0), inc_b);
        wr(3, 1, 8'h00);
        wr(0, 0, 8'h00);
        chk("R11 latch untouched", int'(key_code), 5'h1E);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule